// File: doc/BRIEF.md
# Reloadable Down-Count Timer with Overflow Interrupt

This block is a register-programmed down counter for periodic events. Software loads a reload value, picks a raw divider in a timebase register, and then sets a run bit and, if wanted, an interrupt-enable bit. A prescaler turns the system clock into count ticks. The count falls by one on each tick. A tick that arrives while the count is zero sets a sticky overflow flag, raises the interrupt request when interrupts are enabled, and reloads the count.

The counter width is a parameter. A 12-bit width gives the timer variant, in which reload values that do not fit in 12 bits are refused. A 32-bit width gives the counter variant. The host acknowledges an interrupt in two writes: it writes zero to the control register, which drops the request and freezes the count, and then writes the old control value back, which resumes counting from the frozen value. A status register reports the overflow flag, the armed and counting conditions and the pending request as separate bits. Reading the status register clears the overflow flag. The current count can be read at any time.

Top module: `reload_timer`

## Requirements
- R1: After reset the control, reload, timebase, status and value registers all read 0, and `irq` is low.
- R2: A write to the reload register (address 1) stores the value and also loads it into the count. A value with any bit set at or above bit CNT_W is refused, and neither the reload register nor the count changes.
- R3: The control register (address 0) holds interrupt-enable in bit 0 and run-enable in bit 1, and it reads back as written. The count falls by one per tick only while run-enable is 1. With run-enable at 0 the count holds its value.
- R4: A tick that arrives while the count is 0 reloads the count from the reload register, sets the overflow flag, and sets `irq` if interrupt-enable is 1. The result is one event every reload+1 ticks.
- R5: With interrupt-enable at 0, `irq` stays low through terminal counts, while the overflow flag is still set.
- R6: The status register (address 3) reads overflow in bit 0, interrupt-enable in bit 1, run-enable in bit 2 and a pending request in bit 3. Overflow stays set until the status register is read, and that read clears it.
- R7: Writing 0 to the control register clears `irq` and freezes the count. Writing the previous control value back resumes counting from the frozen count.
- R8: With timebase N (address 2), a tick occurs every N+1 clocks while running. The prescaler restarts when run-enable is set. A reload write leaves the timebase unchanged.
- R9: The value register (address 4) returns the current count, and it can be read while counting is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` is valid after the next clock edge |
| addr | input | 3 | Register address (0 control, 1 reload, 2 timebase, 3 status, 4 value) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt request, held high until acknowledged |

## Verification
The count is exercised with a timebase of 0 and a timebase of 3. Stopping after a fixed number of clocks gives remainders that tell a per-clock tick apart from a divided tick. A short reload of 2 shows that the event period is reload+1 ticks, because the bench checks the cycle in which `irq` rises and the count that follows the wrap. Runs with and without interrupt-enable separate the sticky overflow flag from the request. Out-of-range reload writes, reads taken while counting, and the zero-then-restore acknowledge with its resume show whether the count is frozen or disturbed.

// File: rtl/rtm_pkg.sv
package rtm_pkg;

  // Register addresses
  typedef enum logic [2:0] {
    RA_CTRL     = 3'd0,
    RA_RELOAD   = 3'd1,
    RA_TIMEBASE = 3'd2,
    RA_STATUS   = 3'd3,
    RA_VALUE    = 3'd4
  } rtm_addr_e;

  // Control register bits
  localparam int CTRL_IRQ_BIT = 0;
  localparam int CTRL_RUN_BIT = 1;
  localparam int CTRL_W       = 2;

  // Status register bits
  localparam int ST_OVF_BIT   = 0;
  localparam int ST_ARMED_BIT = 1;
  localparam int ST_RUN_BIT   = 2;
  localparam int ST_PEND_BIT  = 3;
  localparam int ST_W         = 4;

endpackage

// File: rtl/rtm_rst_sync.sv
module rtm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  // Reset is asserted at once and released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/rtm_regs.sv
module rtm_regs
  import rtm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12,
  parameter int TB_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              irq_en,
  output logic              run_en,
  output logic [CNT_W-1:0]  reload_q,
  output logic [TB_W-1:0]   tb_q,
  output logic              load_pulse,
  output logic              ack_clr
);

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  reload_d;
  logic [TB_W-1:0]   tb_d;
  logic              wr_ctrl, wr_reload, wr_tb;
  logic              in_range;

  // The range check applies only when the count is narrower than the bus
  generate
    if (CNT_W < DATA_W) begin : g_narrow
      assign in_range = ~|wdata[DATA_W-1:CNT_W];
    end else begin : g_full
      assign in_range = 1'b1;
    end
  endgenerate

  assign wr_ctrl   = wr_en && (addr == RA_CTRL);
  assign wr_reload = wr_en && (addr == RA_RELOAD) && in_range;
  assign wr_tb     = wr_en && (addr == RA_TIMEBASE);

  // Next-state logic
  always_comb begin
    ctrl_d   = ctrl_q;
    reload_d = reload_q;
    tb_d     = tb_q;
    if (wr_ctrl)   ctrl_d   = wdata[CTRL_W-1:0];
    if (wr_reload) reload_d = wdata[CNT_W-1:0];
    if (wr_tb)     tb_d     = wdata[TB_W-1:0];
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      tb_q     <= '0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= ctrl_d;
      if (wr_reload) reload_q <= reload_d;
      if (wr_tb)     tb_q     <= tb_d;
    end
  end

  assign irq_en     = ctrl_q[CTRL_IRQ_BIT];
  assign run_en     = ctrl_q[CTRL_RUN_BIT];
  assign load_pulse = wr_reload;
  assign ack_clr    = wr_ctrl && !wdata[CTRL_IRQ_BIT];

  AST_RELOAD_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_RELOAD && !in_range) |=> $stable(reload_q)); // R2

  AST_TB_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_RELOAD) |=> $stable(tb_q)); // R8

endmodule

// File: rtl/rtm_prescale.sv
module rtm_prescale #(
  parameter int TB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  input  logic [TB_W-1:0] tb_q,
  output logic            tick
);

  logic [TB_W-1:0] pre_q, pre_d;

  assign tick = run_en && (pre_q == tb_q);

  // Next-state: the prescaler sits at zero while stopped
  always_comb begin
    if (!run_en)   pre_d = '0;
    else if (tick) pre_d = '0;
    else           pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && tb_q != '0 && $stable(tb_q)) |=> !tick); // R8

endmodule

// File: rtl/rtm_core.sv
module rtm_core #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_pulse,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_q,
  input  logic             irq_en,
  input  logic             ack_clr,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count_q,
  output logic             ovf_q,
  output logic             irq_q
);

  logic [CNT_W-1:0] count_d;
  logic             ovf_d, irq_d;
  logic             terminal;

  assign terminal = tick && !load_pulse && (count_q == '0);

  // Next-state logic
  always_comb begin
    count_d = count_q;
    if (load_pulse)    count_d = load_val;
    else if (terminal) count_d = reload_q;
    else if (tick)     count_d = count_q - 1'b1;

    ovf_d = ovf_q;
    if (ovf_clr)  ovf_d = 1'b0;
    if (terminal) ovf_d = 1'b1;

    irq_d = irq_q;
    if (ack_clr)             irq_d = 1'b0;
    if (terminal && irq_en)  irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      ovf_q   <= ovf_d;
      irq_q   <= irq_d;
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_pulse) |=> $stable(count_q)); // R3

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_pulse && count_q == '0) |=> (ovf_q && count_q == $past(reload_q))); // R4

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && !irq_en) |=> !irq_q); // R5

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q); // R6

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr && !(tick && count_q == '0)) |=> !irq_q); // R7

endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rtm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12,
  parameter int TB_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  logic              rst_n_s;
  logic              irq_en, run_en;
  logic [CNT_W-1:0]  reload_q, count_q;
  logic [TB_W-1:0]   tb_q;
  logic              load_pulse, ack_clr, tick;
  logic              ovf_q, irq_q, ovf_clr;
  logic [ST_W-1:0]   status;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  rtm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  rtm_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .TB_W(TB_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .irq_en     (irq_en),
    .run_en     (run_en),
    .reload_q   (reload_q),
    .tb_q       (tb_q),
    .load_pulse (load_pulse),
    .ack_clr    (ack_clr)
  );

  rtm_prescale #(.TB_W(TB_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .run_en (run_en),
    .tb_q   (tb_q),
    .tick   (tick)
  );

  rtm_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .tick       (tick),
    .load_pulse (load_pulse),
    .load_val   (wdata[CNT_W-1:0]),
    .reload_q   (reload_q),
    .irq_en     (irq_en),
    .ack_clr    (ack_clr),
    .ovf_clr    (ovf_clr),
    .count_q    (count_q),
    .ovf_q      (ovf_q),
    .irq_q      (irq_q)
  );

  assign ovf_clr = rd_en && (addr == RA_STATUS);

  always_comb begin
    status               = '0;
    status[ST_OVF_BIT]   = ovf_q;
    status[ST_ARMED_BIT] = irq_en;
    status[ST_RUN_BIT]   = run_en;
    status[ST_PEND_BIT]  = irq_q;
  end

  // Read mux, registered on the read strobe
  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      case (addr)
        RA_CTRL:     rdata_d = DATA_W'({run_en, irq_en});
        RA_RELOAD:   rdata_d = DATA_W'(reload_q);
        RA_TIMEBASE: rdata_d = DATA_W'(tb_q);
        RA_STATUS:   rdata_d = DATA_W'(status);
        RA_VALUE:    rdata_d = DATA_W'(count_q);
        default:     rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)   rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n_s |=> !irq); // R1

  AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ovf_clr && !(tick && !load_pulse && count_q == '0)) |=> !ovf_q); // R6

endmodule

// File: tb/reload_timer_test.sv
module reload_timer_test;

  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en, rd_en;
  logic [2:0]        addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              irq;

  int checks   = 0;
  int failures = 0;

  typedef struct {
    logic [DATA_W-1:0] val;
    string             tag;
  } exp_t;

  exp_t exp_q[$];

  reload_timer #(.DATA_W(DATA_W), .CNT_W(12), .TB_W(8)) uut (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
  );

  always #5 clk = ~clk;

  // Each operation uses exactly one rising edge and returns 1 ns after it
  task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [DATA_W-1:0] e, input string tag);
    exp_t item;
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
    item.val = e; item.tag = tag;
    exp_q.push_back(item);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] e);
    checks++;
    if (act !== e) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, e);
    end
  endtask

  // Monitor: compares read data against the scoreboard
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t item;
      item = exp_q.pop_front();
      chk(item.tag, rdata, item.val);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(3'd0, 32'd0, "R1 ctrl");
    rd(3'd1, 32'd0, "R1 reload");
    rd(3'd2, 32'd0, "R1 timebase");
    rd(3'd3, 32'd0, "R1 status");
    rd(3'd4, 32'd0, "R1 value");

    // R2 reload range: 12-bit width refuses 0x1234
    wr(3'd1, 32'h5);
    wr(3'd1, 32'h1234);
    rd(3'd1, 32'h5, "R2 reload kept");
    rd(3'd4, 32'h5, "R2 count kept");

    // R8 timebase 3: ticks at arm+4 and arm+8, stopped at arm+9
    wr(3'd2, 32'd3);
    wr(3'd1, 32'd100);
    rd(3'd2, 32'd3, "R8 timebase after reload write");
    wr(3'd0, 32'd2);
    idle(8);
    wr(3'd0, 32'd0);
    rd(3'd4, 32'd98, "R8 divided tick count");
    wr(3'd2, 32'd0);

    // R3 one tick per clock, four ticks before stop lands
    wr(3'd1, 32'd10);
    wr(3'd0, 32'd3);
    rd(3'd0, 32'd3, "R3 ctrl readback");
    idle(2);
    wr(3'd0, 32'd0);
    rd(3'd4, 32'd6, "R3 decrement");
    idle(5);
    rd(3'd4, 32'd6, "R3 hold while stopped");

    // R9 read while counting
    wr(3'd1, 32'd50);
    wr(3'd0, 32'd2);
    idle(4);
    rd(3'd4, 32'd46, "R9 live value");
    wr(3'd0, 32'd0);
    rd(3'd4, 32'd44, "R9 value after stop");

    // R4 wrap with reload 2: irq three ticks after arming
    wr(3'd1, 32'd2);
    wr(3'd0, 32'd3);
    idle(2);
    chk("R4 irq before terminal", {31'd0, irq}, 32'd0);
    idle(1);
    chk("R4 irq at terminal", {31'd0, irq}, 32'd1);
    // R7 acknowledge: zero write
    wr(3'd0, 32'd0);
    chk("R7 irq cleared", {31'd0, irq}, 32'd0);
    rd(3'd3, 32'h1, "R6 overflow sticky");
    rd(3'd3, 32'h0, "R6 cleared by read");
    rd(3'd4, 32'd1, "R7 count frozen");
    // R7 restore
    wr(3'd0, 32'd3);
    idle(1);
    chk("R7 resumed no irq yet", {31'd0, irq}, 32'd0);
    idle(1);
    chk("R7 resumed irq", {31'd0, irq}, 32'd1);
    rd(3'd3, 32'hF, "R6 all status bits");
    wr(3'd0, 32'd0);
    rd(3'd4, 32'd0, "R4 count after wrap");

    // R5 run without interrupt enable
    wr(3'd3 - 3'd2, 32'd1);
    wr(3'd0, 32'd2);
    idle(4);
    chk("R5 irq stays low", {31'd0, irq}, 32'd0);
    wr(3'd0, 32'd0);
    rd(3'd3, 32'h1, "R5 overflow without irq");

    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule